// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a processor core and presents one at a time as a request line plus a 14-bit vector address. Seven external active-low pins pass through a two-flop synchronizer. One of these pins is a non-maskable power-down request. Six internal peripheral strobes also feed the block: two serial transmitters, two serial receivers, a byte DMA engine and a timer. Some sources are remembered in pending latches and others are followed as levels. A mask, a global enable, force and clear strobes, and a nesting mode decide which pending source is offered to the core.

The core takes an offered vector with a one-cycle acknowledge and later signals return-from-interrupt. The block keeps its own record of which sources are in service. It uses that record to decide whether a new request may preempt the current one, or whether requests must wait until servicing is sequential again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The 11 sources have a fixed priority, highest first. Index 0 is power-down (vector 0x002C). The remaining indices i = 1..10 get vector 4*i, in this order: IRQ2, IRQL1, IRQL0, serial-0 transmit, serial-0 receive, IRQE, byte DMA, serial-1 transmit slot, serial-1 receive slot, timer. `irq_vec` shows the vector of the highest eligible source whenever `irq_req` is 1.
- R2: Bit i of the mask (1 = enabled) gates source i. Bit 0 is ignored, so power-down can never be masked.
- R3: In the cycle after a cycle with `mask_we` high, `irq_req` is 0. In the cycle after that, the new mask applies.
- R4: `pin_n` is ordered as follows: bit 0 power-down, 1 IRQ2, 2 IRQL1, 3 IRQL0, 4 IRQE, 5 IRQ1, 6 IRQ0. Power-down and IRQE are always edge-latched. IRQL1 and IRQL0 are always level-sensitive. IRQ2, IRQ1 and IRQ0 are edge-latched when `edge_sel` bit 0, 1 or 2 respectively is 1, and level-sensitive otherwise. An edge latch is set by a synchronized high-to-low transition and stays set after the pin returns high.
- R5: The `periph_req` bits are one-cycle strobes that set pending latches. Bit 0 is serial-0 transmit, 1 serial-0 receive, 2 byte DMA, 3 serial-1 transmit, 4 serial-1 receive, 5 timer.
- R6: Bit i of `frc_set` or `frc_clr` sets or clears the latch of source i when that source is edge-latched. Both have no effect on level-sensitive sources.
- R7: After reset the mask is all zero and servicing is enabled. `ints_dis` blocks every source, including power-down, until `ints_ena`.
- R8: When `nest_en` is 1, a source is offered only if its priority is strictly higher than that of every source in service.
- R9: When `nest_en` is 0, nothing is offered while any source is in service.
- R10: An `rti` pulse removes the highest-priority source from the in-service set.
- R11: `irq_ack` while `irq_req` is 1 puts the offered source in service and clears its latch. A new set event on that source in the same cycle wins, and the source stays pending.
- R12: When `s1_as_irq` is 1, source 8 follows pin IRQ1 and source 9 follows pin IRQ0. When it is 0, they follow `periph_req` bits 3 and 4, and the pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 7 | External active-low request pins |
| periph_req | input | 6 | Internal peripheral request strobes |
| edge_sel | input | 3 | Edge mode for IRQ2, IRQ1, IRQ0 |
| s1_as_irq | input | 1 | Serial-1 slots take external pins |
| nest_en | input | 1 | Allow preemption by higher priority |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | New mask value |
| frc_set | input | 11 | Force latched sources pending |
| frc_clr | input | 11 | Clear latched sources |
| ints_ena | input | 1 | Enable servicing |
| ints_dis | input | 1 | Disable servicing |
| irq_ack | input | 1 | Core accepts offered vector |
| rti | input | 1 | Core returns from interrupt |
| irq_req | output | 1 | Interrupt offered to core |
| irq_vec | output | 14 | Vector address of offered interrupt |

## Verification
The delicate coincidence is an acknowledge of the timer falling in the same cycle as a fresh timer strobe. The latch clear and the latch set then meet on one register. The bench drives both in one cycle with nesting on. It then expects no offer, because the source is in service and not strictly higher. After `rti`, the timer vector must reappear, which shows that the set won over the clear. A second case with the same flavour writes the mask while a level request is already active. The bench then expects exactly one silent cycle before the offer.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC  = 11;
  localparam int NPIN  = 7;
  localparam int NPER  = 6;
  localparam int VEC_W = 14;
  localparam int NEDGE = 3;

  // source indices, ascending index = descending priority
  localparam int S_PWD  = 0;
  localparam int S_IRQ2 = 1;
  localparam int S_IL1  = 2;
  localparam int S_IL0  = 3;
  localparam int S_S0TX = 4;
  localparam int S_S0RX = 5;
  localparam int S_IRQE = 6;
  localparam int S_BDMA = 7;
  localparam int S_S1TX = 8;
  localparam int S_S1RX = 9;
  localparam int S_TMR  = 10;

  // pin positions
  localparam int P_PWD  = 0;
  localparam int P_IRQ2 = 1;
  localparam int P_IL1  = 2;
  localparam int P_IL0  = 3;
  localparam int P_IRQE = 4;
  localparam int P_IRQ1 = 5;
  localparam int P_IRQ0 = 6;

  function automatic logic [VEC_W-1:0] src_vector(input int unsigned i);
    if (i == 0) return VEC_W'(16'h002C);
    return VEC_W'(i * 4);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= pin_n;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_n = s2_q;
  assign fall  = s3_q & ~s2_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lat,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  input  logic [N-1:0] frc_set,
  input  logic [N-1:0] frc_clr,
  output logic [N-1:0] pend_q
);
  logic [N-1:0] pend_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pend_d[i] = pend_q[i];
      if (clr_ev[i] || frc_clr[i]) pend_d[i] = 1'b0;
      if (set_ev[i] || frc_set[i]) pend_d[i] = 1'b1;
      if (!lat[i])                 pend_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 11,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NS = NSRC,
  parameter int VW = VEC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_n,
  input  logic [NPER-1:0] periph_req,
  input  logic [NEDGE-1:0] edge_sel,
  input  logic            s1_as_irq,
  input  logic            nest_en,
  input  logic            mask_we,
  input  logic [NS-1:0]   mask_wdata,
  input  logic [NS-1:0]   frc_set,
  input  logic [NS-1:0]   frc_clr,
  input  logic            ints_ena,
  input  logic            ints_dis,
  input  logic            irq_ack,
  input  logic            rti,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec
);
  localparam int IW = (NS > 1) ? $clog2(NS) : 1;

  logic [NPIN-1:0] pin_lvl_n, pin_fall;
  logic [NS-1:0]   lat, set_ev, lvl, clr_ev, pend_q, raw, cand, allow, elig;
  logic [NS-1:0]   mask_q, mask_d, isr_q, isr_d;
  logic            blk_q, glob_en_q, glob_en_d;
  logic            sel_hit, isr_hit, ack_hit;
  logic [IW-1:0]   sel_idx, isr_idx;

  irq_pin_sync #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .lvl_n(pin_lvl_n), .fall(pin_fall)
  );

  // source classification: latched or level, and their events
  always_comb begin
    lat    = '0;
    set_ev = '0;
    lvl    = '0;
    lat[S_PWD]     = 1'b1;  set_ev[S_PWD]  = pin_fall[P_PWD];
    lat[S_IRQ2]    = edge_sel[0];
    set_ev[S_IRQ2] = pin_fall[P_IRQ2];
    lvl[S_IRQ2]    = ~pin_lvl_n[P_IRQ2];
    lvl[S_IL1]     = ~pin_lvl_n[P_IL1];
    lvl[S_IL0]     = ~pin_lvl_n[P_IL0];
    lat[S_S0TX]    = 1'b1;  set_ev[S_S0TX] = periph_req[0];
    lat[S_S0RX]    = 1'b1;  set_ev[S_S0RX] = periph_req[1];
    lat[S_IRQE]    = 1'b1;  set_ev[S_IRQE] = pin_fall[P_IRQE];
    lat[S_BDMA]    = 1'b1;  set_ev[S_BDMA] = periph_req[2];
    lat[S_TMR]     = 1'b1;  set_ev[S_TMR]  = periph_req[5];
    if (s1_as_irq) begin
      lat[S_S1TX]    = edge_sel[1];
      set_ev[S_S1TX] = pin_fall[P_IRQ1];
      lvl[S_S1TX]    = ~pin_lvl_n[P_IRQ1];
      lat[S_S1RX]    = edge_sel[2];
      set_ev[S_S1RX] = pin_fall[P_IRQ0];
      lvl[S_S1RX]    = ~pin_lvl_n[P_IRQ0];
    end else begin
      lat[S_S1TX]    = 1'b1;
      set_ev[S_S1TX] = periph_req[3];
      lat[S_S1RX]    = 1'b1;
      set_ev[S_S1RX] = periph_req[4];
    end
  end

  assign ack_hit = irq_ack & sel_hit;

  always_comb begin
    clr_ev = '0;
    if (ack_hit) clr_ev[sel_idx] = 1'b1;
  end

  irq_pend_bank #(.N(NS)) u_pend (
    .clk(clk), .rst_n(rst_n), .lat(lat), .set_ev(set_ev), .clr_ev(clr_ev),
    .frc_set(frc_set), .frc_clr(frc_clr), .pend_q(pend_q)
  );

  assign raw  = (lat & pend_q) | (~lat & lvl);
  assign cand = raw & {mask_q[NS-1:1], 1'b1} & {NS{glob_en_q & ~blk_q}};

  irq_prio_pick #(.N(NS)) u_isr_pick (.req(isr_q), .hit(isr_hit), .idx(isr_idx));

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      if (nest_en) allow[i] = ~isr_hit | (i < int'(isr_idx));
      else         allow[i] = ~isr_hit;
    end
  end

  assign elig = cand & allow;

  irq_prio_pick #(.N(NS)) u_sel_pick (.req(elig), .hit(sel_hit), .idx(sel_idx));

  assign irq_req = sel_hit;
  assign irq_vec = sel_hit ? VW'(src_vector(int'(sel_idx))) : '0;

  // next state
  always_comb begin
    isr_d = isr_q;
    if (rti && isr_hit) isr_d[isr_idx] = 1'b0;
    if (ack_hit)        isr_d[sel_idx] = 1'b1;
    mask_d = mask_we ? mask_wdata : mask_q;
    glob_en_d = glob_en_q;
    if (ints_ena) glob_en_d = 1'b1;
    if (ints_dis) glob_en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q     <= '0;
      mask_q    <= '0;
      blk_q     <= 1'b0;
      glob_en_q <= 1'b1;
    end else begin
      isr_q     <= isr_d;
      mask_q    <= mask_d;
      blk_q     <= mask_we;
      glob_en_q <= glob_en_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NS = 11,
  parameter int VW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mask_we,
  input logic          nest_en,
  input logic          irq_ack,
  input logic          rti,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic          glob_en_q,
  input logic [NS-1:0] isr_q
);
  a_r3_mask_write_silences: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_we) |-> !irq_req);

  a_r1_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[1:0] == 2'b00 && irq_vec <= VW'(16'h002C)));

  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en_q |-> !irq_req);

  a_r9_sequential_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!nest_en && isr_q != '0) |-> !irq_req);

  a_r11_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !rti) |=> $countones(isr_q) == $countones($past(isr_q)) + 1);

  a_r10_rti_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !irq_ack && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NS(NS), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .nest_en(nest_en),
  .irq_ack(irq_ack), .rti(rti), .irq_req(irq_req), .irq_vec(irq_vec),
  .glob_en_q(glob_en_q), .isr_q(isr_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic        clk, rst_n;
  logic [6:0]  pin_n;
  logic [5:0]  periph_req;
  logic [2:0]  edge_sel;
  logic        s1_as_irq, nest_en, mask_we, ints_ena, ints_dis, irq_ack, rti;
  logic [10:0] mask_wdata, frc_set, frc_clr;
  logic        irq_req;
  logic [13:0] irq_vec;
  int n_chk = 0;
  int n_bad = 0;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .periph_req(periph_req),
    .edge_sel(edge_sel), .s1_as_irq(s1_as_irq), .nest_en(nest_en),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .frc_set(frc_set),
    .frc_clr(frc_clr), .ints_ena(ints_ena), .ints_dis(ints_dis),
    .irq_ack(irq_ack), .rti(rti), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // pins[32:26] mask[25:15] req[14] vec[13:0]; level pins, serial-1 slots on pins
  localparam logic [32:0] TBL [10] = '{
    {7'h7F, 11'h7FF, 1'b0, 14'h0000},
    {7'h3F, 11'h7FF, 1'b1, 14'h0024},
    {7'h1F, 11'h7FF, 1'b1, 14'h0020},
    {7'h17, 11'h7FF, 1'b1, 14'h000C},
    {7'h13, 11'h7FF, 1'b1, 14'h0008},
    {7'h11, 11'h7FF, 1'b1, 14'h0004},
    {7'h11, 11'h7FD, 1'b1, 14'h0008},
    {7'h11, 11'h7F1, 1'b1, 14'h0020},
    {7'h11, 11'h000, 1'b0, 14'h0000},
    {7'h11, 11'h200, 1'b1, 14'h0024}
  };

  task automatic check(input string tag, input logic er, input logic [13:0] ev);
    n_chk++;
    if (irq_req !== er || (er && irq_vec !== ev)) begin
      n_bad++;
      $display("FAIL %s: got req=%0b vec=%h, expected req=%0b vec=%h",
               tag, irq_req, irq_vec, er, ev);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mask(input logic [10:0] m);
    @(negedge clk); mask_wdata = m; mask_we = 1'b1;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic pin_pulse(input int b);
    @(negedge clk); pin_n[b] = 1'b0;
    @(negedge clk); pin_n[b] = 1'b1;
  endtask

  task automatic per_pulse(input int b);
    @(negedge clk); periph_req[b] = 1'b1;
    @(negedge clk); periph_req[b] = 1'b0;
  endtask

  task automatic ack_once();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic rti_once();
    @(negedge clk); rti = 1'b1;
    @(negedge clk); rti = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_n = '1; periph_req = '0; edge_sel = '0; s1_as_irq = 1'b1;
    nest_en = 1'b0; mask_we = 1'b0; mask_wdata = '0; frc_set = '0; frc_clr = '0;
    ints_ena = 1'b0; ints_dis = 1'b0; irq_ack = 1'b0; rti = 1'b0;
    cyc(3);
    check("R7 reset idle", 1'b0, 14'h0);
    rst_n = 1'b1;

    // R7: mask is zero after reset
    pin_n[3] = 1'b0;
    cyc(4);
    check("R7 mask cleared at reset", 1'b0, 14'h0);
    // R3: one silent cycle after the write, then the new mask applies
    @(negedge clk); mask_wdata = 11'h7FF; mask_we = 1'b1;
    @(negedge clk); mask_we = 1'b0;
    check("R3 blocked cycle", 1'b0, 14'h0);
    @(negedge clk);
    check("R3 after block", 1'b1, 14'h000C);
    pin_n[3] = 1'b1;
    cyc(4);
    check("R4 level released", 1'b0, 14'h0);

    // R1 R2 R12: priority table, level sensing
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      pin_n = TBL[k][32:26]; mask_wdata = TBL[k][25:15]; mask_we = 1'b1;
      @(negedge clk); mask_we = 1'b0;
      cyc(4);
      check($sformatf("R1 R2 table %0d", k), TBL[k][14], TBL[k][13:0]);
    end
    @(negedge clk); pin_n = '1;
    wr_mask(11'h7FF);
    cyc(4);

    // R4 R11: IRQE edge latch, cleared by acknowledge
    pin_pulse(4);
    cyc(4);
    check("R4 IRQE latched", 1'b1, 14'h0018);
    ack_once();
    rti_once();
    check("R11 ack cleared latch", 1'b0, 14'h0);

    // R6: force and clear
    @(negedge clk); frc_set[6] = 1'b1;
    @(negedge clk); frc_set[6] = 1'b0;
    check("R6 force IRQE", 1'b1, 14'h0018);
    @(negedge clk); frc_clr[6] = 1'b1;
    @(negedge clk); frc_clr[6] = 1'b0;
    check("R6 clear IRQE", 1'b0, 14'h0);
    @(negedge clk); frc_set[3] = 1'b1;
    @(negedge clk); frc_set[3] = 1'b0;
    check("R6 force ignored on level", 1'b0, 14'h0);

    // R2 R7: power-down unmaskable, but gated by global disable
    wr_mask(11'h000);
    cyc(2);
    pin_pulse(0);
    cyc(4);
    check("R2 power-down unmaskable", 1'b1, 14'h002C);
    @(negedge clk); ints_dis = 1'b1;
    @(negedge clk); ints_dis = 1'b0;
    check("R7 global disable", 1'b0, 14'h0);
    @(negedge clk); ints_ena = 1'b1;
    @(negedge clk); ints_ena = 1'b0;
    check("R7 global enable", 1'b1, 14'h002C);
    ack_once();
    rti_once();
    check("R11 power-down retired", 1'b0, 14'h0);
    wr_mask(11'h7FF);
    cyc(2);

    // R4: IRQ2 in edge mode
    @(negedge clk); edge_sel = 3'b001;
    pin_pulse(1);
    cyc(4);
    check("R4 IRQ2 edge latched", 1'b1, 14'h0004);
    ack_once();
    rti_once();
    @(negedge clk); edge_sel = 3'b000;

    // R5 R8 R10: nesting
    @(negedge clk); nest_en = 1'b1;
    per_pulse(5);
    check("R5 timer strobe", 1'b1, 14'h0028);
    ack_once();
    per_pulse(1);
    check("R8 higher preempts", 1'b1, 14'h0014);
    ack_once();
    per_pulse(2);
    check("R8 lower held", 1'b0, 14'h0);
    rti_once();
    check("R10 highest retired", 1'b1, 14'h001C);
    ack_once();
    rti_once();
    rti_once();
    check("R10 all retired", 1'b0, 14'h0);

    // R9: sequential servicing
    @(negedge clk); nest_en = 1'b0;
    per_pulse(5);
    ack_once();
    per_pulse(0);
    check("R9 held while busy", 1'b0, 14'h0);
    rti_once();
    check("R9 offered after return", 1'b1, 14'h0010);
    ack_once();
    rti_once();

    // R11: acknowledge and new strobe on the same source in one cycle
    @(negedge clk); nest_en = 1'b1;
    per_pulse(5);
    @(negedge clk); irq_ack = 1'b1; periph_req[5] = 1'b1;
    @(negedge clk); irq_ack = 1'b0; periph_req[5] = 1'b0;
    check("R11 in service, not offered", 1'b0, 14'h0);
    rti_once();
    check("R11 set wins over clear", 1'b1, 14'h0028);
    ack_once();
    rti_once();
    check("R11 drained", 1'b0, 14'h0);

    // R12: serial-1 slots from peripherals
    @(negedge clk); s1_as_irq = 1'b0; pin_n[6] = 1'b0;
    cyc(4);
    check("R12 pin ignored", 1'b0, 14'h0);
    per_pulse(4);
    check("R12 serial-1 receive strobe", 1'b1, 14'h0024);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule